// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A prescaler divides the reference clock into a one-second step. With the default parameter, that reference is 32.768 kHz. Each step ripples carries through the chain. The block handles months of 28, 29, 30 and 31 days and applies leap-year correction to February. A control bit chooses between a 24-hour count and a 12-hour count with a PM flag.

A host loads one field per cycle through a simple write port. Reset stands for a complete loss of power. After reset every field takes a known starting value and the counter stays frozen. It starts counting only once the host has written at least one byte. Every host write also restarts the sub-second prescaler, so the next second is a full period long.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 0, date 01, month 01, year 00, with 24-hour mode selected. No field changes until the first host write.
- R2: When `wr_en` is high at a clock edge, the byte on `wr_data` is loaded into the field chosen by `wr_sel`, and it is visible after that edge. The field codes are: 0 seconds, 1 minutes, 2 hours (bits 5:0 kept), 3 day of week (bits 2:0 kept), 4 date, 5 month, 6 year, 7 control. In the control byte, bit 0 set to 1 selects 12-hour mode.
- R3: Any host write enables counting and restarts the prescaler. Seconds first advance on the clock edge TICKS cycles after the write edge, and then every TICKS cycles. A write cycle never advances time.
- R4: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R5: In 24-hour mode the hour byte counts 00 to 23 in BCD. The step from 23 to 00 carries into the day.
- R6: In 12-hour mode, hour bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. The hour runs 12, 01, 02 up to 11. The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM carries into the day.
- R7: Day of week counts 0 to 6. It advances on every day carry and wraps from 6 to 0.
- R8: On a day carry the date wraps to 01 after the last day of its month and carries into the month. The last day is 30 for months 04, 06, 09 and 11, 31 for the other months except February, and 28 for February (29 in a leap year).
- R9: The year is BCD 00 to 99. Any year whose value is divisible by 4, including 00, is a leap year.
- R10: Month counts 01 to 12 and wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (TICKS cycles per second) |
| rst_n | input | 1 | Active-low reset, models total power loss |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field code of the write |
| wr_data | input | 8 | Byte written |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, BCD; bit 5 is PM in 12-hour mode |
| dow | output | 3 | Day of week 0..6 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Two-digit year, BCD |
| mode12 | output | 1 | 1 when 12-hour mode is selected |

## Verification
The assertions take for granted that the host writes only legal BCD values for each field. This means a date no later than the last day of its month, and an hour byte that fits the hour mode in force. They also assume the mode bit changes only together with a matching hour rewrite. The bench keeps to this rule. Its writes are built from binary values through a BCD conversion, and the dates it writes are taken from its own month-length model. It reloads the hour after every mode change. Each rollover case is staged by writing a full time that ends one second before the carry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_CTRL  = 3'd7
  } rtc_field_e;

  typedef struct packed {
    logic [7:0] hour;
    logic       day_wrap;
  } hour_step_t;

  // one BCD step, assumes a legal two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return {3'd0, v[7:4]} * 7'd10 + {3'd0, v[3:0]};
  endfunction

  // sixty-count step for seconds and minutes
  function automatic logic [7:0] base60_next(input logic [7:0] v);
    if (v == 8'h59) return 8'h00;
    return bcd_inc(v);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic hour_step_t hour_next(input logic [7:0] hr, input logic mode12);
    hour_step_t r;
    logic [7:0] inc;
    r.day_wrap = 1'b0;
    inc = bcd_inc({3'd0, hr[4:0]});
    if (mode12) begin
      case (hr[4:0])
        5'h12:   r.hour = {2'b00, hr[5], 5'h01};
        5'h11: begin
          r.hour     = {2'b00, ~hr[5], 5'h12};
          r.day_wrap = hr[5];
        end
        default: r.hour = {2'b00, hr[5], inc[4:0]};
      endcase
    end else if (hr == 8'h23) begin
      r.hour     = 8'h00;
      r.day_wrap = 1'b1;
    end else begin
      r.hour = bcd_inc(hr);
    end
    return r;
  endfunction

  function automatic logic [2:0] dow_next(input logic [2:0] d);
    if (d >= 3'd6) return 3'd0;
    return d + 3'd1;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  // a write cycle never produces a second step
  assign tick    = run & at_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart || !run || at_last) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode12,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       min_carry,
  output logic       hour_carry,
  output logic       day_carry
);
  hour_step_t hstep;

  assign min_carry  = tick & (sec == 8'h59);
  assign hour_carry = min_carry & (min == 8'h59);
  assign hstep      = hour_next(hour, mode12);
  assign day_carry  = hour_carry & hstep.day_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else if (wr_en) begin
      case (rtc_field_e'(wr_sel))
        FLD_SEC:  sec  <= wr_data;
        FLD_MIN:  min  <= wr_data;
        FLD_HOUR: hour <= {2'b00, wr_data[5:0]};
        default: ;
      endcase
    end else begin
      if (tick)       sec  <= base60_next(sec);
      if (min_carry)  min  <= base60_next(min);
      if (hour_carry) hour <= hstep.hour;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [2:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       month_carry,
  output logic       year_carry
);
  logic [7:0] month_end;

  assign month_end   = last_date(month, year);
  assign month_carry = day_carry & (date == month_end);
  assign year_carry  = month_carry & (month == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow   <= 3'd0;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else if (wr_en) begin
      case (rtc_field_e'(wr_sel))
        FLD_DOW:   dow   <= wr_data[2:0];
        FLD_DATE:  date  <= wr_data;
        FLD_MONTH: month <= wr_data;
        FLD_YEAR:  year  <= wr_data;
        default: ;
      endcase
    end else begin
      if (day_carry) begin
        dow  <= dow_next(dow);
        date <= month_carry ? 8'h01 : bcd_inc(date);
      end
      if (month_carry) month <= year_carry ? 8'h01 : bcd_inc(month);
      if (year_carry)  year  <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [2:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       mode12
);
  // named internal events, observed by the bound checker
  logic run;
  logic tick;
  logic min_carry;
  logic hour_carry;
  logic day_carry;
  logic month_carry;
  logic year_carry;

  // counting stays frozen after power loss until the first host byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mode12 <= 1'b0;
    end else if (wr_en) begin
      run <= 1'b1;
      if (rtc_field_e'(wr_sel) == FLD_CTRL) mode12 <= wr_data[0];
    end
  end

  rtc_prescaler #(.TICKS(TICKS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (wr_en),
    .tick    (tick)
  );

  rtc_time_chain u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode12     (mode12),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .sec        (sec),
    .min        (min),
    .hour       (hour),
    .min_carry  (min_carry),
    .hour_carry (hour_carry),
    .day_carry  (day_carry)
  );

  rtc_date_chain u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry   (day_carry),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .dow         (dow),
    .date        (date),
    .month       (month),
    .year        (year),
    .month_carry (month_carry),
    .year_carry  (year_carry)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int TICKS = 32768
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       run,
  input logic       tick,
  input logic       day_carry,
  input logic       mode12,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [2:0] dow,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year
);
  localparam int GW = $clog2(TICKS + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(TICKS);
  localparam logic [GW-1:0] GAP_LAST = GW'(TICKS - 1);

  // cycles since the last write or second step, saturating
  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap <= '0;
    else if (wr_en || tick)   gap <= '0;
    else if (gap != GAP_MAX)  gap <= gap + 1'b1;
  end

  AST_FROZEN_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable({sec, min, hour, dow, date, month, year})); // R1
  AST_NO_STEP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R1
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == GAP_LAST)); // R3
  AST_NO_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tick); // R3
  AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec)); // R4
  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec <= 8'h59) && (sec[3:0] <= 4'd9)); // R4
  AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !mode12) |=> (hour == 8'h00 && min == 8'h00 && sec == 8'h00)); // R5
  AST_MIDNIGHT_12: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && mode12) |=> (hour == 8'h12 && min == 8'h00 && sec == 8'h00)); // R6
  AST_DOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (dow == (($past(dow) == 3'd6) ? 3'd0 : $past(dow) + 3'd1))); // R7
  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    date != 8'h00); // R8
  AST_MONTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (month >= 8'h01) && (month <= 8'h12)); // R10
endmodule

bind rtc_calendar rtc_calendar_chk #(.TICKS(TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .run       (run),
  .tick      (tick),
  .day_carry (day_carry),
  .mode12    (mode12),
  .sec       (sec),
  .min       (min),
  .hour      (hour),
  .dow       (dow),
  .date      (date),
  .month     (month),
  .year      (year)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 3;
  localparam logic [2:0] F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DOW = 3'd3,
                         F_DATE = 3'd4, F_MONTH = 3'd5, F_YEAR = 3'd6, F_CTRL = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] dow;
  logic       mode12;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_calendar #(.TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date), .month(month),
    .year(year), .mode12(mode12)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cal(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                         input logic [2:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr);
    wr(F_YEAR, yr); wr(F_MONTH, mo); wr(F_DATE, dt); wr(F_DOW, {5'd0, dw});
    wr(F_HOUR, hr); wr(F_MIN, mi); wr(F_SEC, se);
  endtask

  task automatic one_second();
    repeat (TICKS) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, then frozen
    chk("R1", "sec", sec, 8'h00);   chk("R1", "min", min, 8'h00);
    chk("R1", "hour", hour, 8'h00); chk("R1", "dow", {5'd0, dow}, 8'h00);
    chk("R1", "date", date, 8'h01); chk("R1", "month", month, 8'h01);
    chk("R1", "year", year, 8'h00); chk("R1", "mode12", {7'd0, mode12}, 8'h00);
    repeat (10 * TICKS) @(negedge clk);
    chk("R1", "sec frozen", sec, 8'h00);
    chk("R1", "date frozen", date, 8'h01);

    // R2 field loads, visible right after the write edge
    wr(F_YEAR, 8'h37);  chk("R2", "year load", year, 8'h37);
    wr(F_MONTH, 8'h09); chk("R2", "month load", month, 8'h09);
    wr(F_DATE, 8'h15);  chk("R2", "date load", date, 8'h15);
    wr(F_DOW, 8'h04);   chk("R2", "dow load", {5'd0, dow}, 8'h04);
    wr(F_HOUR, 8'h17);  chk("R2", "hour load", hour, 8'h17);
    wr(F_MIN, 8'h42);   chk("R2", "min load", min, 8'h42);
    wr(F_CTRL, 8'h01);  chk("R2", "ctrl load", {7'd0, mode12}, 8'h01);
    wr(F_CTRL, 8'h00);  chk("R2", "ctrl clear", {7'd0, mode12}, 8'h00);
    wr(F_SEC, 8'h10);   chk("R2", "sec load", sec, 8'h10);

    // R3 first step exactly TICKS cycles after the write, then every TICKS
    repeat (TICKS - 1) @(negedge clk);
    chk("R3", "before first step", sec, 8'h10);
    @(negedge clk);
    chk("R3", "first step", sec, 8'h11);
    repeat (TICKS - 1) @(negedge clk);
    chk("R3", "before second step", sec, 8'h11);
    @(negedge clk);
    chk("R3", "second step", sec, 8'h12);
    // a write in mid-second restarts the count
    @(negedge clk);
    wr(F_MIN, 8'h05);
    repeat (TICKS - 1) @(negedge clk);
    chk("R3", "restart holds sec", sec, 8'h12);
    @(negedge clk);
    chk("R3", "restart step", sec, 8'h13);

    // R4 continuous run across minute and hour carries in 24-hour mode
    begin
      int s, m, h;
      s = 30; m = 58; h = 0;
      set_cal(8'h00, 8'h58, 8'h30, 3'd0, 8'h01, 8'h01, 8'h00);
      for (int i = 0; i < 100; i++) begin
        one_second();
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        chk("R4", "run sec", sec, bcd(s));
        chk("R4", "run min", min, bcd(m));
        chk("R5", "run hour", hour, bcd(h));
      end
    end

    // R5 every 24-hour value at the end of its hour
    for (int h = 0; h < 24; h++) begin
      set_cal(bcd(h), 8'h59, 8'h59, 3'd2, 8'h01, 8'h01, 8'h00);
      one_second();
      chk("R5", "hour step", hour, bcd((h + 1) % 24));
      chk("R4", "min wrap", min, 8'h00);
      chk("R5", "day carry", date, (h == 23) ? 8'h02 : 8'h01);
    end

    // R7 day of week at midnight for every value
    for (int d = 0; d < 7; d++) begin
      set_cal(8'h23, 8'h59, 8'h59, 3'(d), 8'h10, 8'h05, 8'h20);
      one_second();
      chk("R7", "dow step", {5'd0, dow}, bcd((d + 1) % 7));
    end

    // R6 every 12-hour value, AM and PM
    wr(F_CTRL, 8'h01);
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        logic [7:0] exp_h;
        set_cal({2'b00, pm[0], bcd(h)[4:0]}, 8'h59, 8'h59, 3'd0, 8'h01, 8'h01, 8'h00);
        one_second();
        if (h == 12)      exp_h = {2'b00, pm[0], 5'h01};
        else if (h == 11) exp_h = {2'b00, ~pm[0], 5'h12};
        else              exp_h = {2'b00, pm[0], bcd(h + 1)[4:0]};
        chk("R6", "12h step", hour, exp_h);
        chk("R6", "12h day carry", date, (h == 11 && pm == 1) ? 8'h02 : 8'h01);
        chk("R7", "12h dow", {5'd0, dow}, (h == 11 && pm == 1) ? 8'h01 : 8'h00);
      end
    end
    wr(F_CTRL, 8'h00);

    // R8 R9 R10 last day of every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_cal(8'h23, 8'h59, 8'h59, 3'd0, bcd(dim(m, y)), bcd(m), bcd(y));
        one_second();
        chk("R8", "month end date", date, 8'h01);
        chk("R10", "month step", month, bcd((m % 12) + 1));
        chk("R10", "year step", year, bcd((m == 12) ? (y + 1) % 100 : y));
      end
      // R9 the 28th of February
      set_cal(8'h23, 8'h59, 8'h59, 3'd0, 8'h28, 8'h02, bcd(y));
      one_second();
      chk("R9", "feb 28 next", date, (y % 4 == 0) ? 8'h29 : 8'h01);
    end
    // R8 the day before the month end stays in the month
    for (int m = 1; m <= 12; m++) begin
      set_cal(8'h23, 8'h59, 8'h59, 3'd0, bcd(dim(m, 1) - 1), bcd(m), 8'h01);
      one_second();
      chk("R8", "no early wrap", date, bcd(dim(m, 1)));
      chk("R8", "month kept", month, bcd(m));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule